// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a 32-bit control and status register that tells software why the most recent system reset happened. Software can also use it to ask for a new reset. Two kinds of software-requested reset exist. A soft power-on request re-arms power-on tracking, so the reset that follows is recorded as a power-on reset. A soft external-initiated request asks for a reset and leaves that tracking alone. Two button inputs record a button power-on event and a button external-initiated event as cause bits.

Only five bits carry meaning. Bit 31 is the power-on cause, bit 30 the soft power-on request, bit 29 the soft external-initiated request, bit 28 the button power-on cause and bit 27 the button external-initiated cause. The register sits in the upper word of an 8-byte slot. The `word_sel_i` input is high for that word, and the other word reads as zero and ignores writes.

A saturating boot counter follows how many system resets have been applied since the block itself was powered up. It starts at zero. When `sys_rst_i` arrives while the counter is zero, the register is loaded with only the power-on bit, and the counter then counts up. Driving the actual reset tree is left to logic outside this block. This block only issues a one-cycle request, `reset_req_o`.

Top module: `reset_cause_status`

## Requirements
- R1: After `rst_n` is released, the upper word reads 0x00000000, `por_pending_o` is 1 and `reset_req_o` is 0.
- R2: Bits 26 to 0 always read as zero. With `word_sel_i` low, `rdata_o` is 0x00000000 whatever the register holds.
- R3: A write with `word_sel_i` low changes neither the register nor the boot counter, and it raises no reset request.
- R4: Bits 31, 28 and 27 are write-one-to-clear. Writing 1 clears the bit and writing 0 leaves it unchanged.
- R5: Bits 30 and 29 take the value written to them. Written bits 26 to 0 have no effect.
- R6: A write with bit 30 set raises `reset_req_o` for exactly one cycle, on the clock edge that takes the write. It also zeroes the boot counter, so `por_pending_o` reads 1.
- R7: A write with bit 29 set and bit 30 clear raises the same one-cycle `reset_req_o` and leaves the boot counter unchanged.
- R8: A `sys_rst_i` cycle with `por_pending_o` high loads the register with 0x80000000 and clears `por_pending_o`. With `por_pending_o` low, it leaves the register unchanged.
- R9: A rising edge on `btn_por_i` sets bit 28, and a rising edge on `btn_xir_i` sets bit 27. A level held high does not set the bit again after software clears it.
- R10: When a button rising edge falls in the same cycle as a write that clears the same bit, the bit ends up set.
- R11: A register write in the same cycle as `sys_rst_i` is discarded: it changes no bit and raises no request.
- R12: The boot counter saturates. Any number of `sys_rst_i` cycles without a soft power-on request never brings `por_pending_o` back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset of the block itself |
| word_sel_i | input | 1 | High selects the upper word of the slot, where the register lives |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word chosen by `word_sel_i` |
| sys_rst_i | input | 1 | One-cycle indication that a system reset is being applied |
| btn_por_i | input | 1 | Button power-on reset level |
| btn_xir_i | input | 1 | Button external-initiated reset level |
| reset_req_o | output | 1 | One-cycle system reset request |
| por_pending_o | output | 1 | High when the next system reset will count as power-on |

## Verification
Several events can land on the register in the same cycle. A button edge can meet a software clear of the same cause bit. A system reset can meet a register write that carries a request. The bench provokes each pair by driving both stimuli at the same falling edge. For the first pair it reads the register back on the next falling edge and expects the set to win. For the second pair it expects no request pulse and an unchanged register. A sweep over all 32 values of the five significant written bits, each applied from a state with every cause bit set, checks the clear rules and the request pulse against a bench model built one bit at a time.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_BTN  = 2;

  // Bit positions; software decodes these, so they are fixed.
  localparam int unsigned POR_BIT  = 31;
  localparam int unsigned SPOR_BIT = 30;
  localparam int unsigned SXIR_BIT = 29;
  localparam int unsigned BPOR_BIT = 28;
  localparam int unsigned BXIR_BIT = 27;

  localparam logic [WORD_W-1:0] ONE_W = WORD_W'(1);

  localparam logic [WORD_W-1:0] POR_ONLY   = ONE_W << POR_BIT;
  localparam logic [WORD_W-1:0] W1C_MASK   = (ONE_W << POR_BIT) | (ONE_W << BPOR_BIT) |
                                             (ONE_W << BXIR_BIT);
  localparam logic [WORD_W-1:0] DIRECT_MASK = (ONE_W << SPOR_BIT) | (ONE_W << SXIR_BIT);
  localparam logic [WORD_W-1:0] LIVE_MASK  = W1C_MASK | DIRECT_MASK;

  // Cause bit that button index i sets.
  function automatic int unsigned btn_bit(input int unsigned i);
    return (i == 0) ? BPOR_BIT : BXIR_BIT;
  endfunction

  // New register value after a software write.
  function automatic logic [WORD_W-1:0] merge_write(input logic [WORD_W-1:0] cur,
                                                    input logic [WORD_W-1:0] wval);
    logic [WORD_W-1:0] v;
    v = wval & LIVE_MASK;
    return (cur & ~(v & W1C_MASK) & ~DIRECT_MASK) | (v & DIRECT_MASK);
  endfunction

  function automatic logic wants_reset(input logic [WORD_W-1:0] wval);
    return wval[SPOR_BIT] | wval[SXIR_BIT];
  endfunction

endpackage

// File: rtl/rcs_edge_detect.sv
module rcs_edge_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  for (genvar g = 0; g < N; g++) begin : g_ch
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q;

    // R9: a level held high produces no second edge
    held_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i[g] && $past(lvl_i[g])) |-> !rise_o[g]);
  end

endmodule

// File: rtl/rcs_boot_counter.sv
module rcs_boot_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst_i,
  input  logic rearm_i,
  output logic first_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (sys_rst_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    else if (!sys_rst_i && rearm_i)          cnt_q <= '0;
  end

  assign first_o = (cnt_q == '0);

  // R6
  rearm_sets_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_i && !sys_rst_i) |=> first_o);
  // R12
  reset_clears_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i |=> !first_o);
  // R7
  idle_keeps_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_i && !rearm_i) |=> $stable(first_o));

endmodule

// File: rtl/rcs_cause_reg.sv
module rcs_cause_reg
  import rcs_pkg::*;
#(
  parameter int unsigned N = NUM_BTN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_i,
  input  logic              first_i,
  input  logic              wr_take_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [N-1:0]      btn_rise_i,
  output logic [WORD_W-1:0] cause_o
);

  logic [WORD_W-1:0] cause_q, base_d, set_d;

  always_comb begin
    if (sys_rst_i)      base_d = first_i ? POR_ONLY : cause_q;
    else if (wr_take_i) base_d = merge_write(cause_q, wdata_i);
    else                base_d = cause_q;
    set_d = '0;
    for (int unsigned i = 0; i < N; i++)
      if (btn_rise_i[i]) set_d[btn_bit(i)] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= base_d | set_d;
  end

  assign cause_o = cause_q;

  // R2: reserved bits never hold a one
  always_comb reserved_zero_chk: assert ((cause_q & ~LIVE_MASK) == '0);

  // R8
  por_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_i && first_i && btn_rise_i == '0) |=> cause_q == POR_ONLY);
  // R8
  late_reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_i && !first_i && btn_rise_i == '0) |=> $stable(cause_q));
  // R3
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst_i && !wr_take_i && btn_rise_i == '0) |=> $stable(cause_q));
  // R10
  btn0_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise_i[0] |=> cause_q[btn_bit(0)]);
  // R10
  btn1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise_i[N-1] |=> cause_q[btn_bit(N-1)]);

endmodule

// File: rtl/reset_cause_status.sv
module reset_cause_status
  import rcs_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_sel_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              sys_rst_i,
  input  logic              btn_por_i,
  input  logic              btn_xir_i,
  output logic              reset_req_o,
  output logic              por_pending_o
);

  logic              wr_take, rearm, req_fire, first, req_q;
  logic [NUM_BTN-1:0] btn_lvl, btn_rise;
  logic [WORD_W-1:0] cause;

  assign wr_take  = wr_en_i & word_sel_i & ~sys_rst_i;
  assign rearm    = wr_take & wdata_i[SPOR_BIT];
  assign req_fire = wr_take & wants_reset(wdata_i);
  assign btn_lvl  = {btn_xir_i, btn_por_i};

  rcs_edge_detect #(.N(NUM_BTN)) edge_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(btn_lvl), .rise_o(btn_rise));

  rcs_boot_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .sys_rst_i(sys_rst_i), .rearm_i(rearm), .first_o(first));

  rcs_cause_reg #(.N(NUM_BTN)) reg_i (
    .clk(clk), .rst_n(rst_n), .sys_rst_i(sys_rst_i), .first_i(first),
    .wr_take_i(wr_take), .wdata_i(wdata_i), .btn_rise_i(btn_rise), .cause_o(cause));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_fire;
  end

  assign reset_req_o   = req_q;
  assign por_pending_o = first;
  assign rdata_o       = word_sel_i ? cause : '0;

  // R6
  req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req_o |-> $past(wr_en_i && word_sel_i && wants_reset(wdata_i)));
  // R11
  req_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i |=> !reset_req_o);
  // R3
  low_word_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_sel_i |=> !reset_req_o);
  // R2
  always_comb low_word_zero_chk: assert (word_sel_i || rdata_o == '0);

endmodule

// File: tb/reset_cause_status_tb_top.sv
module reset_cause_status_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_sel = 1'b1, wr_en = 1'b0, sys_rst = 1'b0;
  logic        btn_por = 1'b0, btn_xir = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        reset_req, por_pending;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  reset_cause_status dut_i (
    .clk(clk), .rst_n(rst_n), .word_sel_i(word_sel), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .sys_rst_i(sys_rst),
    .btn_por_i(btn_por), .btn_xir_i(btn_xir),
    .reset_req_o(reset_req), .por_pending_o(por_pending));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_hi(input string req, input logic [31:0] exp);
    word_sel = 1'b1; #1;
    check(req, rdata, exp);
  endtask

  task automatic por_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; sys_rst = 1'b0;
    btn_por = 1'b0; btn_xir = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Write at one falling edge; returns at the next, where the request is visible.
  task automatic wr(input logic sel, input logic [31:0] d);
    word_sel = sel; wr_en = 1'b1; wdata = d;
    @(negedge clk); wr_en = 1'b0; word_sel = 1'b1;
  endtask

  task automatic sys_pulse();
    sys_rst = 1'b1;
    @(negedge clk); sys_rst = 1'b0;
  endtask

  // Bench model of a write on the five live bits.
  function automatic logic [31:0] model_wr(input logic [31:0] cur, input logic [31:0] d);
    logic [31:0] r;
    r = cur;
    for (int b = 27; b < 32; b++) begin
      if (b == 29 || b == 30) r[b] = d[b];
      else if (d[b])          r[b] = 1'b0;
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    por_reset();
    // R1
    read_hi("R1 reg", 32'h0);
    check("R1 por_pending", {31'd0, por_pending}, 32'd1);
    check("R1 reset_req", {31'd0, reset_req}, 32'd0);

    // R8: first system reset loads the power-on cause
    sys_pulse();
    read_hi("R8 por load", 32'h8000_0000);
    check("R8 pending cleared", {31'd0, por_pending}, 32'd0);
    // R2: lower word and reserved bits
    word_sel = 1'b0; #1;
    check("R2 low word", rdata, 32'h0);
    // R3: lower-word write ignored
    wr(1'b0, 32'hFFFF_FFFF);
    check("R3 no req", {31'd0, reset_req}, 32'd0);
    read_hi("R3 reg kept", 32'h8000_0000);
    check("R3 count kept", {31'd0, por_pending}, 32'd0);

    // R7: soft external request, counter unchanged
    wr(1'b1, 32'h2000_0000);
    check("R7 pulse", {31'd0, reset_req}, 32'd1);
    @(negedge clk);
    check("R7 single cycle", {31'd0, reset_req}, 32'd0);
    check("R7 pending", {31'd0, por_pending}, 32'd0);
    read_hi("R7 reg", 32'hA000_0000);
    sys_pulse();
    read_hi("R8 late reset keeps", 32'hA000_0000);

    // R6: soft power-on re-arms
    wr(1'b1, 32'h4000_0000);
    check("R6 pulse", {31'd0, reset_req}, 32'd1);
    check("R6 pending", {31'd0, por_pending}, 32'd1);
    read_hi("R6 reg", 32'hC000_0000);
    sys_pulse();
    read_hi("R6 then R8 load", 32'h8000_0000);

    // R9: button edges, held levels
    btn_por = 1'b1; @(negedge clk);
    read_hi("R9 btn por", 32'h9000_0000);
    wr(1'b1, 32'h1000_0000);
    @(negedge clk);
    read_hi("R9 held no reset", 32'h8000_0000);
    btn_por = 1'b0; btn_xir = 1'b1; @(negedge clk);
    read_hi("R9 btn xir", 32'h8800_0000);
    btn_xir = 1'b0; @(negedge clk);

    // R10: button edge against clear of same bit
    wr(1'b1, 32'h0800_0000);
    read_hi("R10 prep", 32'h8000_0000);
    btn_xir = 1'b1;
    wr(1'b1, 32'h0800_0000);
    read_hi("R10 set wins", 32'h8800_0000);
    btn_xir = 1'b0; @(negedge clk);

    // R11: write during system reset is dropped (counter nonzero)
    sys_rst = 1'b1;
    wr(1'b1, 32'h6800_0000);
    sys_rst = 1'b0;
    check("R11 no req", {31'd0, reset_req}, 32'd0);
    read_hi("R11 reg kept", 32'h8800_0000);
    check("R11 count kept", {31'd0, por_pending}, 32'd0);

    // R12: saturation
    for (int k = 0; k < 40; k++) sys_pulse();
    check("R12 no wrap", {31'd0, por_pending}, 32'd0);
    read_hi("R12 reg", 32'h8800_0000);

    // R4 R5: sweep of the five live write bits from an all-set state
    for (int w = 0; w < 32; w++) begin
      logic [31:0] d, exp;
      por_reset();
      sys_pulse();
      btn_por = 1'b1; btn_xir = 1'b1; @(negedge clk);
      btn_por = 1'b0; btn_xir = 1'b0;
      wr(1'b1, 32'h6000_0000);
      read_hi("R4 sweep prep", 32'hF800_0000);
      d = {w[4:0], 27'h2AA_AAAA ^ 27'(w)};
      exp = model_wr(32'hF800_0000, d);
      wr(1'b1, d);
      check("R6 R7 sweep req", {31'd0, reset_req}, {31'd0, d[30] | d[29]});
      read_hi("R4 R5 sweep reg", exp);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule